// File: doc/BRIEF.md
# Destination-Register Bit Manipulation Unit

This unit computes the new value for a 32-bit data register under one of four operations picked by a 2-bit select. It can mirror the bit order of the operand, mirror its byte order, or scan it from the most significant bit for the first set bit. In the scan, the result is the offset of that bit counted down from the top. The fourth select code returns the operand unchanged. The result always replaces the whole destination word. Condition codes, register-file access and decoding belong to the surrounding pipeline.

All three operations are built side by side from the same operand. A select multiplexer picks one of them. With the output register enabled (`REG_OUT = 1`, the default), the chosen result and a valid flag are captured on the clock edge after a valid input. The result register loads only when an input is valid and keeps its value between operations. With `REG_OUT = 0`, the unit is purely combinational. Because the datapath is select-driven, the unit has no state beyond that output stage: a single "capture" transition happens on each valid input, and an "idle hold" transition happens on every other cycle.

Top module: `dreg_bitops`

## Requirements
- R1: With select code 00 (bit mirror), result bit k equals operand bit 31-k for every k from 0 to 31.
- R2: With select code 01 (byte mirror), result byte j equals operand byte 3-j, where byte 0 is bits 7:0 and byte 3 is bits 31:24.
- R3: With select code 10 (first-one scan) and a nonzero operand, the result is 31 minus the index of the highest set bit. A set bit 31 gives 0, and a highest set bit at bit 0 gives 31. The upper result bits are zero.
- R4: With select code 10 and an all-zero operand, the result is 32.
- R5: With select code 11, the result equals the operand.
- R6: With the output register enabled, `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. The result for that input appears in the same cycle.
- R7: While `rst_n` is low and right after it is released, `out_valid` and `out_data` are zero.
- R8: In a cycle where `in_valid` is low, `out_data` keeps its previous value, whatever the operand and select inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and select are valid this cycle |
| in_op | input | 2 | Operation select: 00 bit mirror, 01 byte mirror, 10 first-one scan, 11 pass |
| in_data | input | 32 | Source operand |
| out_valid | output | 1 | Result valid |
| out_data | output | 32 | Replacement value for the destination register |

## Verification
The output stage is the only state. A wrong capture enable shows up one cycle after the stimulus, either as a missing or extra `out_valid` pulse or as `out_data` drifting during idle cycles while the inputs toggle. A fault in one of the operation paths shows up in the very next result that uses that select code. For this reason the scan is driven at its two end positions, at middle positions and with a zero operand, and the mirrors are driven with asymmetric patterns so that any swapped lane differs at the ports.

// File: rtl/dreg_bitops_pkg.sv
package dreg_bitops_pkg;

    typedef enum logic [1:0] {
        OP_BIT_MIRROR  = 2'b00,
        OP_BYTE_MIRROR = 2'b01,
        OP_FIRST_ONE   = 2'b10,
        OP_PASS        = 2'b11
    } bitop_e;

    typedef enum logic {
        ST_IDLE_HOLD = 1'b0,
        ST_CAPTURE   = 1'b1
    } outstage_e;

endpackage

// File: rtl/dreg_bit_mirror.sv
module dreg_bit_mirror #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] dst
);
    for (genvar k = 0; k < DATA_W; k++) begin : g_lane
        assign dst[k] = src[DATA_W-1-k];
    end
endmodule

// File: rtl/dreg_byte_mirror.sv
module dreg_byte_mirror #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] dst
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar j = 0; j < NBYTES; j++) begin : g_byte
        assign dst[j*8 +: 8] = src[(NBYTES-1-j)*8 +: 8];
    end
endmodule

// File: rtl/dreg_first_one.sv
module dreg_first_one #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] dst
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] offset;

    // Later (higher) indices overwrite earlier ones, so the highest set bit wins.
    always_comb begin
        offset = CNT_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (src[i]) begin
                offset = CNT_W'(DATA_W - 1 - i);
            end
        end
    end

    always_comb begin
        dst = '0;
        dst[CNT_W-1:0] = offset;
    end
endmodule

// File: rtl/dreg_bitops.sv
module dreg_bitops
    import dreg_bitops_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] bit_res;
    logic [DATA_W-1:0] byte_res;
    logic [DATA_W-1:0] scan_res;
    logic [DATA_W-1:0] sel_res;
    bitop_e            op;

    assign op = bitop_e'(in_op);

    dreg_bit_mirror  #(.DATA_W(DATA_W)) u_bit  (.src(in_data), .dst(bit_res));
    dreg_byte_mirror #(.DATA_W(DATA_W)) u_byte (.src(in_data), .dst(byte_res));
    dreg_first_one   #(.DATA_W(DATA_W)) u_scan (.src(in_data), .dst(scan_res));

    always_comb begin
        unique case (op)
            OP_BIT_MIRROR:  sel_res = bit_res;
            OP_BYTE_MIRROR: sel_res = byte_res;
            OP_FIRST_ONE:   sel_res = scan_res;
            OP_PASS:        sel_res = in_data;
            default:        sel_res = in_data;
        endcase
    end

    if (REG_OUT) begin : g_reg
        outstage_e         stage_q;
        logic [DATA_W-1:0] data_q;

        // State register: capture on a valid input, otherwise idle hold.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= ST_IDLE_HOLD;
            end else begin
                stage_q <= in_valid ? ST_CAPTURE : ST_IDLE_HOLD;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q <= '0;
            end else if (in_valid) begin
                data_q <= sel_res;
            end
        end

        // Output process.
        always_comb begin
            unique case (stage_q)
                ST_CAPTURE:   out_valid = 1'b1;
                ST_IDLE_HOLD: out_valid = 1'b0;
                default:      out_valid = 1'b0;
            endcase
            out_data = data_q;
        end
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_data  = sel_res;
    end
endmodule

// File: rtl/dreg_bitops_chk.sv
module dreg_bitops_chk #(
    parameter int DATA_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    function automatic logic [DATA_W-1:0] flip_bits(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[DATA_W-1-i] = v[i];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] flip_bytes(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r;
        for (int j = 0; j < DATA_W/8; j++) r[(DATA_W/8-1-j)*8 +: 8] = v[j*8 +: 8];
        return r;
    endfunction

    if (REG_OUT) begin : g_seq
        p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_valid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        p_bit_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 2'b00) |=> out_data == flip_bits($past(in_data)));
        p_byte_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 2'b01) |=> out_data == flip_bytes($past(in_data)));
        p_scan_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 2'b10 && in_data[DATA_W-1]) |=> out_data == '0);
        p_scan_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 2'b10 && in_data == '0) |=> out_data == DATA_W'(DATA_W));
        p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_op == 2'b11) |=> out_data == $past(in_data));
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(out_data));
    end

    always_comb begin
        if (!rst_n && REG_OUT) begin
            a_reset_r7: assert (out_valid == 1'b0 && out_data == '0);
        end
    end
endmodule

bind dreg_bitops dreg_bitops_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_dreg_bitops.sv
module tb_dreg_bitops;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [31:0] last_exp = '0;

    typedef struct { logic [31:0] exp; string req; } item_t;
    item_t sb[$];

    dreg_bitops dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] d);
        logic [31:0] r;
        r = d;
        case (op)
            2'b00: for (int k = 0; k < 32; k++) r[k] = d[31-k];
            2'b01: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
            2'b10: begin
                r = 32;
                for (int b = 31; b >= 0; b--) if (d[b]) begin r = 31 - b; break; end
            end
            default: r = d;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [31:0] d, input string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_data = d;
        it.exp = model(op, d); it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_op = 2'(i); in_data = 32'hA5A5_0000 ^ i;
        end
    endtask

    // Monitor: compares each produced result against the queue head (R6: one-cycle latency).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R6 unexpected valid", {31'b0, out_valid}, 32'h0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        check(out_data == it.exp, it.req, out_data, it.exp);
                        last_exp = it.exp;
                    end
                end else begin
                    check(sb.size() == 0, "R6 missing valid", {31'b0, out_valid}, 32'h1);
                    check(out_data == last_exp, "R8 hold", out_data, last_exp);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R7 in reset", out_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R7 after release", out_data, 32'h0);

        drive(2'b00, 32'h0000_0001, "R1 bit mirror lsb");
        drive(2'b00, 32'h1234_5678, "R1 bit mirror pattern");
        drive(2'b00, 32'hF000_000A, "R1 bit mirror edges");
        drive(2'b01, 32'h1122_3344, "R2 byte mirror");
        drive(2'b01, 32'hDEAD_BEEF, "R2 byte mirror pattern");
        drive(2'b10, 32'h8000_0000, "R3 scan bit31");
        drive(2'b10, 32'h0000_0001, "R3 scan bit0");
        drive(2'b10, 32'h0001_FFFF, "R3 scan bit16");
        drive(2'b10, 32'h0F00_0003, "R3 scan bit27");
        drive(2'b10, 32'h0000_0000, "R4 scan zero");
        drive(2'b11, 32'hCAFE_F00D, "R5 pass");
        idle(4);
        drive(2'b10, 32'h0000_0000, "R4 scan zero after idle");
        idle(1);
        drive(2'b01, 32'h0102_0304, "R2 byte mirror single");
        drive(2'b11, 32'h0000_0000, "R5 pass zero");
        idle(5);
        for (int i = 0; i < 32; i++) drive(2'b10, 32'h1 << i, "R3 scan sweep");
        for (int i = 0; i < 8; i++) drive(2'(i), 32'h9E37_79B9 * (i + 1), "R1/R2/R3/R5 mixed");
        idle(4);
        check(sb.size() == 0, "R6 drained", sb.size(), 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule